// File: doc/BRIEF.md
# USB Bridge Command and Dual-Stream Controller

This block is the main sequencer between two camera frame FIFOs and a USB 3.0 bridge chip that runs as a synchronous slave FIFO. The bus is 16 bits wide, and the bridge supplies the interface clock. The controller polls a host-to-device command endpoint and reads 16-bit command words from it. It recognises three of them: a query that returns a fixed three-word image-description packet, a start code and a stop code.

While streaming is on, the controller visits the right and left camera FIFOs in turn. When the visited FIFO holds at least one full burst and the bridge shows the endpoint ready, the controller moves one burst of words to that camera's device-to-host endpoint. Commands are polled only between bursts, so a burst is never cut short.

Top module: `usb_stream_ctrl`

## Requirements
- R1: While reset is held, `rd_n`, `oe_n`, `wr_n` and `pktend_n` are 1, `dq_drive` is 0 and `stream_on` is 0.
- R2: After the command word 0x0101, the block writes exactly three words to endpoint address 1. The first is 0x01AA when `GRAY_MODE` is 1 and 0x01BB otherwise: the image-type code is in the low byte and the dual-stream code 0x01 is in the high byte. The second word is `IMG_W` and the third is `IMG_H`. After the third word, `pktend_n` is low for exactly one cycle on the same address.
- R3: Command words are read only with `ep_addr` = 0 (the command endpoint), and only while `rx_rdy` is 1.
- R4: The command word 0x1111 sets `stream_on` and 0x0f0f clears it. While `stream_on` is 0, no camera data is written, however full the FIFOs are.
- R5: Any other command word leaves `stream_on` unchanged.
- R6: While streaming, each burst is exactly `BURST_WORDS` consecutive words. Right-camera data goes to address 1 and left-camera data to address 2. Each written word is the head word of the matching FIFO, taken in FIFO order.
- R7: A burst starts only when the visited FIFO's level is at least `BURST_WORDS` and `tx_rdy` is 1 for the selected address. Otherwise the turn passes to the other camera.
- R8: A stop command that arrives while a burst is in progress takes effect only after that burst has written all of its words.
- R9: `ep_addr` holds its value for at least two clock cycles before `rd_n` or `wr_n` goes low.
- R10: A command word is sampled on the second rising edge after the edge that drove `rd_n` low. `oe_n` stays low through that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock supplied by the bridge |
| rst_n | input | 1 | Active-low reset |
| dq_in | input | 16 | Data bus, bridge to block |
| dq_out | output | 16 | Data bus, block to bridge |
| dq_drive | output | 1 | High while the block drives the bus |
| ep_addr | output | 2 | Endpoint select: 0 command, 1 right camera, 2 left camera |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| oe_n | output | 1 | Bridge output enable, active low |
| wr_n | output | 1 | Write strobe, active low |
| pktend_n | output | 1 | Short-packet commit, active low |
| rx_rdy | input | 1 | Command endpoint holds a word |
| tx_rdy | input | 1 | Selected transmit endpoint can accept data |
| stream_on | output | 1 | Streaming enabled, sent to both capture units |
| right_level | input | LVLW | Words held in the right FIFO |
| right_rd | output | 1 | Pop from the right FIFO (first-word fall-through) |
| right_data | input | 16 | Head word of the right FIFO |
| left_level | input | LVLW | Words held in the left FIFO |
| left_rd | output | 1 | Pop from the left FIFO (first-word fall-through) |
| left_data | input | 16 | Head word of the left FIFO |

## Verification
A stop command and a camera burst can fall in the same cycle. The bench provokes this by raising `rx_rdy` with the stop code just after the first pop of a burst. It then judges the outcome by three things: the burst must still deliver its full word count in FIFO order, `stream_on` must stay high until that burst ends, and no further camera write may follow. A second overlap is a full right FIFO together with a left FIFO one word short of a burst. Here the bench judges only the arbitration: the right camera is served and the left camera is skipped.

// File: rtl/usb_stream_ctrl.sv
module usb_stream_ctrl #(
  parameter int IMG_W       = 640,
  parameter int IMG_H       = 480,
  parameter int GRAY_MODE   = 1,
  parameter int BURST_WORDS = 8192,
  parameter int FIFO_DEPTH  = 16384,
  localparam int LVLW = $clog2(FIFO_DEPTH + 1),
  localparam int BCW  = $clog2(BURST_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     dq_in,
  output logic [15:0]     dq_out,
  output logic            dq_drive,
  output logic [1:0]      ep_addr,
  output logic            cs_n,
  output logic            rd_n,
  output logic            oe_n,
  output logic            wr_n,
  output logic            pktend_n,
  input  logic            rx_rdy,
  input  logic            tx_rdy,
  output logic            stream_on,
  input  logic [LVLW-1:0] right_level,
  output logic            right_rd,
  input  logic [15:0]     right_data,
  input  logic [LVLW-1:0] left_level,
  output logic            left_rd,
  input  logic [15:0]     left_data
);
  localparam logic [1:0]  EP_CMD = 2'd0, EP_RIGHT = 2'd1, EP_LEFT = 2'd2;
  localparam logic [15:0] CMD_QUERY = 16'h0101, CMD_START = 16'h1111, CMD_STOP = 16'h0f0f;
  localparam logic [7:0]  ITYPE = (GRAY_MODE == 1) ? 8'hAA : 8'hBB;
  localparam logic [7:0]  STYPE = 8'h01;

  typedef enum logic [2:0] {S_ARB, S_SETTLE, S_RD, S_LAT, S_PARAM, S_PEND, S_BURST} state_t;
  typedef enum logic [1:0] {D_CMD, D_BURST, D_PARAM} dest_t;

  state_t         state;
  dest_t          dest;
  logic           phase, side, wait_cnt;
  logic [1:0]     widx;
  logic [BCW-1:0] bcnt;
  logic [15:0]    param_word;
  logic           side_full;

  assign side_full = side ? (left_level  >= LVLW'(BURST_WORDS))
                          : (right_level >= LVLW'(BURST_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_ARB;  dest <= D_CMD;  ep_addr <= EP_CMD;  cs_n <= 1'b1;
      phase <= 1'b0;   side <= 1'b0;   wait_cnt <= 1'b0;
      widx <= '0;      bcnt <= '0;     stream_on <= 1'b0;
    end else begin
      cs_n <= 1'b0;
      case (state)
        S_ARB:
          if (!phase) begin
            ep_addr <= EP_CMD; dest <= D_CMD; wait_cnt <= 1'b0; state <= S_SETTLE;
          end else if (stream_on && side_full) begin
            ep_addr <= side ? EP_LEFT : EP_RIGHT; dest <= D_BURST;
            wait_cnt <= 1'b0; state <= S_SETTLE;
          end else begin
            phase <= 1'b0; side <= ~side;
          end
        S_SETTLE:
          if (!wait_cnt) wait_cnt <= 1'b1;
          else case (dest)
            D_CMD:
              if (rx_rdy) state <= S_RD;
              else begin phase <= 1'b1; state <= S_ARB; end
            D_BURST:
              if (tx_rdy) begin bcnt <= '0; state <= S_BURST; end
              else begin side <= ~side; phase <= 1'b0; state <= S_ARB; end
            default:
              if (tx_rdy) begin widx <= '0; state <= S_PARAM; end
          endcase
        S_RD: state <= S_LAT;
        S_LAT: begin
          phase <= 1'b1; state <= S_ARB;
          case (dq_in)
            CMD_START: stream_on <= 1'b1;
            CMD_STOP:  stream_on <= 1'b0;
            CMD_QUERY: begin
              ep_addr <= EP_RIGHT; dest <= D_PARAM; wait_cnt <= 1'b0; state <= S_SETTLE;
            end
            default: ;
          endcase
        end
        S_PARAM:
          if (widx == 2'd2) state <= S_PEND;
          else widx <= widx + 2'd1;
        S_PEND: begin phase <= 1'b1; state <= S_ARB; end
        S_BURST:
          if (bcnt == BCW'(BURST_WORDS - 1)) begin
            side <= ~side; phase <= 1'b0; state <= S_ARB;
          end else bcnt <= bcnt + 1'b1;
        default: state <= S_ARB;
      endcase
    end
  end

  always_comb
    case (widx)
      2'd0:    param_word = {STYPE, ITYPE};
      2'd1:    param_word = 16'(IMG_W);
      default: param_word = 16'(IMG_H);
    endcase

  assign rd_n     = !(state == S_RD);
  assign oe_n     = !(state == S_RD || state == S_LAT);
  assign wr_n     = !(state == S_PARAM || state == S_BURST);
  assign pktend_n = !(state == S_PEND);
  assign dq_drive = !wr_n;
  assign right_rd = (state == S_BURST) && !side;
  assign left_rd  = (state == S_BURST) && side;
  assign dq_out   = (state == S_PARAM) ? param_word : (side ? left_data : right_data);

  // R9
  addr_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> ($stable(ep_addr) && ep_addr == $past(ep_addr, 2)));
  // R2
  pktend_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pktend_n) |-> ($past(!wr_n) && $stable(ep_addr) && ep_addr == EP_RIGHT));
  // R6
  pop_matches_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (right_rd || left_rd) |-> (!wr_n && ep_addr == (right_rd ? EP_RIGHT : EP_LEFT)));
  // R7
  burst_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(right_rd) |-> right_level >= LVLW'(BURST_WORDS)) and
    ($rose(left_rd)  |-> left_level  >= LVLW'(BURST_WORDS)));
  // R5
  stream_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_on != $past(stream_on)) |-> $past(!oe_n && rd_n));
  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && ep_addr != EP_RIGHT && ep_addr != EP_CMD && state == S_BURST &&
     bcnt != BCW'(BURST_WORDS - 1)) |=> !wr_n);
endmodule

// File: tb/usb_stream_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_stream_ctrl_tb_top;
  localparam int BW = 16, FD = 64, IW = 1280, IH = 720;
  localparam int LVLW = $clog2(FD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] dq_in = 16'hDEAD, dq_out, right_data, left_data;
  logic dq_drive, cs_n, rd_n, oe_n, wr_n, pktend_n, stream_on, right_rd, left_rd;
  logic [1:0] ep_addr;
  logic rx_rdy = 1'b0, tx_ok_r = 1'b1, tx_ok_l = 1'b1, tx_rdy;
  logic [LVLW-1:0] right_level, left_level;
  int r_in = 0, r_out = 0, l_in = 0, l_out = 0;
  int n_chk = 0, n_bad = 0;
  int r_wr = 0, l_wr = 0, param_left = 0, param_done = 0, run = 0, stab = 0;
  logic [15:0] cmd_word = 16'h0;
  bit rd_seen = 0, last_param = 0;
  logic [15:0] pexp [3];

  always #10 clk = ~clk;

  assign tx_rdy      = (ep_addr == 2'd1) ? tx_ok_r : (ep_addr == 2'd2) ? tx_ok_l : 1'b0;
  assign right_level = LVLW'(r_in - r_out);
  assign left_level  = LVLW'(l_in - l_out);
  assign right_data  = 16'h1000 + 16'(r_out);
  assign left_data   = 16'h2000 + 16'(l_out);

  usb_stream_ctrl #(.IMG_W(IW), .IMG_H(IH), .GRAY_MODE(1), .BURST_WORDS(BW), .FIFO_DEPTH(FD)) dut_i (
    .clk(clk), .rst_n(rst_n), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive),
    .ep_addr(ep_addr), .cs_n(cs_n), .rd_n(rd_n), .oe_n(oe_n), .wr_n(wr_n),
    .pktend_n(pktend_n), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .stream_on(stream_on),
    .right_level(right_level), .right_rd(right_rd), .right_data(right_data),
    .left_level(left_level), .left_rd(left_rd), .left_data(left_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (right_rd) r_out <= r_out + 1;
    if (left_rd)  l_out <= l_out + 1;
  end

  // command endpoint model: word valid exactly at the second edge after the read strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      dq_in = cmd_word;
      check(!oe_n, "R10 oe_n during read latency", oe_n, 0);
    end else dq_in = 16'hDEAD;
    rd_seen = !rd_n;
    if (!rd_n) begin
      check(ep_addr == 2'd0 && rx_rdy, "R3 read address", ep_addr, 0);
      rx_rdy = 1'b0;
    end
  end

  // bus monitor
  always @(negedge clk) if (rst_n) begin
    if ((!rd_n || !wr_n) && run == 0 && !last_param)
      check(stab >= 2, "R9 address settle", stab, 2);
    if (!wr_n) begin
      if (param_left > 0) begin
        check(ep_addr == 2'd1 && dq_out == pexp[3-param_left], "R2 param word", dq_out, pexp[3-param_left]);
        param_left--;
        last_param = (param_left == 0);
      end else begin
        run++;
        if (ep_addr == 2'd1) begin
          check(dq_out == 16'h1000 + 16'(r_wr), "R6 right data", dq_out, 16'h1000 + 16'(r_wr)); r_wr++;
        end else begin
          check(ep_addr == 2'd2 && dq_out == 16'h2000 + 16'(l_wr), "R6 left data", dq_out, 16'h2000 + 16'(l_wr)); l_wr++;
        end
      end
    end else begin
      if (run > 0) check(run == BW, "R6 burst length", run, BW);
      run = 0;
      if (!pktend_n) begin
        check(last_param && ep_addr == 2'd1, "R2 pktend after last word", last_param, 1);
        param_done++;
      end
      last_param = 0;
    end
  end

  logic [1:0] prev_addr = 2'd0;
  always @(negedge clk) begin
    stab = (ep_addr == prev_addr) ? stab + 1 : 0;
    prev_addr = ep_addr;
  end

  task automatic send_cmd(input logic [15:0] w);
    cmd_word = w;
    rx_rdy = 1'b1;
    for (int i = 0; i < 200 && rx_rdy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rw, lw;
    pexp[0] = 16'h01AA; pexp[1] = 16'(IW); pexp[2] = 16'(IH);
    repeat (3) @(negedge clk);
    check(rd_n && oe_n && wr_n && pktend_n && !dq_drive && !stream_on, "R1 reset outputs",
          {rd_n, oe_n, wr_n, pktend_n, dq_drive, stream_on}, 6'b111100);
    rst_n = 1'b1;
    idle(5);

    // query packet
    param_left = 3;
    send_cmd(16'h0101);
    idle(20);
    check(param_left == 0 && param_done == 1, "R2 packet complete", param_done, 1);

    // data waiting but streaming off
    r_in += BW; l_in += BW;
    idle(80);
    check(r_wr == 0 && l_wr == 0, "R4 no data while stopped", r_wr + l_wr, 0);

    send_cmd(16'h1234);
    check(stream_on == 1'b0, "R5 unknown word while stopped", stream_on, 0);

    // start: read latency must be honoured for this to land
    send_cmd(16'h1111);
    check(stream_on == 1'b1, "R4 R10 start sets stream", stream_on, 1);
    idle(120);
    check(r_wr == BW && l_wr == BW, "R6 one burst each", r_wr + l_wr, 2 * BW);

    // left one word short, right full
    r_in += BW; l_in += BW - 1;
    idle(150);
    check(r_wr == 2 * BW, "R7 full right served", r_wr, 2 * BW);
    check(l_wr == BW, "R7 short left skipped", l_wr, BW);
    l_in += 1;
    idle(150);
    check(l_wr == 2 * BW, "R7 left served once full", l_wr, 2 * BW);

    // endpoint not ready
    tx_ok_r = 1'b0; r_in += BW;
    idle(150);
    check(r_wr == 2 * BW, "R7 no write when not ready", r_wr, 2 * BW);
    tx_ok_r = 1'b1;
    idle(150);
    check(r_wr == 3 * BW, "R7 write after ready", r_wr, 3 * BW);

    send_cmd(16'h0f0e);
    check(stream_on == 1'b1, "R5 unknown word while streaming", stream_on, 1);

    // stop arriving mid-burst
    r_in += BW;
    for (int i = 0; i < 300 && !right_rd; i++) @(negedge clk);
    cmd_word = 16'h0f0f; rx_rdy = 1'b1;
    idle(BW / 2);
    check(stream_on == 1'b1, "R8 stream held during burst", stream_on, 1);
    idle(BW + 40);
    check(r_wr == 4 * BW, "R8 burst completed", r_wr, 4 * BW);
    check(stream_on == 1'b0, "R8 stop applied after burst", stream_on, 0);
    r_in += BW;
    idle(150);
    check(r_wr == 4 * BW, "R4 no data after stop", r_wr, 4 * BW);

    // constrained random rounds
    void'($urandom(32'd1234));
    send_cmd(16'h1111);
    for (int k = 0; k < 10; k++) begin
      r_in += int'($urandom_range(0, 2 * BW));
      l_in += int'($urandom_range(0, 2 * BW));
      if ($urandom_range(0, 2) == 0) begin
        send_cmd(16'h5A00 + 16'($urandom_range(0, 255)));
        check(stream_on == 1'b1, "R5 random junk word", stream_on, 1);
      end
      idle(300);
      rw = r_in - r_out; lw = l_in - l_out;
      check(rw < BW && lw < BW, "R7 random drained", rw + lw, 0);
      check(r_wr % BW == 0 && l_wr % BW == 0, "R6 random whole bursts", r_wr % BW + l_wr % BW, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule